// File: doc/BRIEF.md
# JTAG-to-SPI Packet Bridge

This block sits behind a user-defined JTAG data register and turns a serial packet, shifted in on TDI while the TAP is in its shift state, into one SPI flash transaction. It runs entirely on TCK. A header at the front of the packet gives the transfer mode and the number of bytes. The bridge then frames the flash with chip select, passes the command and payload bits to MOSI, and returns the MISO reply on TDO so the host can collect it in the same scan.

Three modes exist. The short mode carries a length of up to 31 bytes in the header byte itself. The long mode adds an extension byte that supplies the upper length bits. The poll mode sends a command and keeps reading for as long as the host keeps shifting, which lets it watch a busy flag. A second user instruction selects a small read-only register. Scanning that register returns a leading zero byte and then a five-character ASCII revision string, so host software can tell the protocol revision.

Top module: `jtag_spi_bridge`

## Requirements
- R1: After reset, spiCsN is high, spiClk is low and tdo is low.
- R2: While selData and shiftDr are high, zero bits on tdi are skipped. The first 1 bit is the start marker and header bit 0. The next seven bits complete the header, LSB first: bits 2:1 give the mode and bits 7:3 give the low five length bits.
- R3: The length counts the command byte plus every payload byte. In mode 1 (short), the bridge forwards exactly that many bytes, 1 to 31.
- R4: In mode 0 (long), eight more bits follow the header, LSB first. They supply length bits 12:5, so lengths such as 32, 33 and 300 are possible.
- R5: A mode 1 header with a zero length field is ignored, and so is a header with mode 3. Chip select stays high for the rest of that shift.
- R6: In mode 2 (poll), the length field is ignored. The bridge forwards bits to the flash for as long as shiftDr stays high. The reply appears on tdo with the same timing as in R8.
- R7: Each tdi bit that arrives after the header goes to spiMosi in arrival order, so the host sends each byte MSB first. The flash samples the bit on the spiClk rising edge, which falls in the low phase of that TCK cycle.
- R8: Number the data bits 0, 1, 2 and so on, from the first bit after the header. Reply bit m (counted from the first bit after the command byte, MSB first) is on tdo after the TCK rising edge that samples data bit 9+m. The host therefore shifts one extra bit after the packet.
- R9: spiCsN goes low with the first command bit. It stays low for exactly 8 × length spiClk rising edges, and goes high on the next TCK edge.
- R10: If shiftDr falls or updateDr rises, spiCsN goes high on the next TCK edge and the packet ends.
- R11: While selData is low, no header is decoded and spiCsN stays high.
- R12: While selVer and shiftDr are high, scan bit k appears on tdo after the k-th TCK edge. Bits 0 to 7 are zero. Each later byte is one character of the revision string, LSB first, with the first character first. The default string is "2.0" followed by two spaces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | TAP clock, clocks the whole bridge |
| rstN | input | 1 | Active-low synchronous reset |
| selData | input | 1 | Packet user instruction is selected |
| selVer | input | 1 | Revision user instruction is selected |
| shiftDr | input | 1 | TAP is in the data shift state |
| updateDr | input | 1 | TAP is in the data update state |
| tdi | input | 1 | Serial packet in |
| tdo | output | 1 | Serial reply out |
| spiCsN | output | 1 | Flash chip select, active low |
| spiClk | output | 1 | Flash clock, inverted TCK gated by the frame |
| spiMosi | output | 1 | Data to the flash |
| spiMiso | input | 1 | Data from the flash |

## Verification
The hardest case to reach is the alignment between the flash's reply and tdo in the last cycles of a frame. The final reply bit is captured on the same edge that closes chip select, and only one extra host bit is there to carry it out. The bench drives full read packets of 31, 32, 33 bytes and a poll scan against a flash model that returns a computed pattern. It rebuilds every reply byte from the tdo bit stream, counting from the decoded header length. A shift that is cut off mid-packet and a header preceded by leading zero bits check the framing edges.

// File: rtl/jtag_spi_bridge_pkg.sv
package jtag_spi_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_EXT,
    ST_DATA,
    ST_TAIL,
    ST_WAIT
  } bridgeState_e;

  localparam logic [1:0] MODE_LONG  = 2'd0;
  localparam logic [1:0] MODE_SHORT = 2'd1;
  localparam logic [1:0] MODE_POLL  = 2'd2;

  // strobes from control to datapath for the current TCK edge
  typedef struct packed {
    logic frameOn;   // this edge carries a bit to the flash
    logic sampleEn;  // capture MISO into the TDO register
    logic clear;     // instruction dropped or update: flush datapath
  } bridgeStrobe_t;

endpackage

// File: rtl/jtag_spi_bridge_ctrl.sv
module jtag_spi_bridge_ctrl
  import jtag_spi_bridge_pkg::*;
#(
  parameter int EXT_W = 8
) (
  input  logic          tck,
  input  logic          rstN,
  input  logic          selData,
  input  logic          shiftDr,
  input  logic          updateDr,
  input  logic          tdi,
  output bridgeStrobe_t st
);

  localparam int LEN_W  = EXT_W + 5;
  localparam int EXTC_W = $clog2(EXT_W);

  bridgeState_e          state;
  logic [5:0]            hdrBits;
  logic [2:0]            hdrCnt;
  logic [EXT_W-2:0]      extBits;
  logic [EXTC_W-1:0]     extCnt;
  logic [2:0]            bitCnt;
  logic [LEN_W-1:0]      bytesLeft;
  logic                  pollMode;

  logic                  abortNow;
  logic [6:0]            nextHdr;
  logic [EXT_W-1:0]      nextExt;
  logic [LEN_W-1:0]      longLen;

  always_comb begin
    abortNow    = !selData || updateDr || !shiftDr;
    nextHdr     = {tdi, hdrBits};
    nextExt     = {tdi, extBits};
    longLen     = {nextExt, hdrBits[5:1]};
    st.frameOn  = (state == ST_DATA) && !abortNow;
    st.sampleEn = ((state == ST_DATA) || (state == ST_TAIL)) && !abortNow;
    st.clear    = !selData || updateDr;
  end

  always_ff @(posedge tck) begin
    if (!rstN || abortNow) begin
      state     <= ST_IDLE;
      hdrBits   <= '0;
      hdrCnt    <= '0;
      extBits   <= '0;
      extCnt    <= '0;
      bitCnt    <= '0;
      bytesLeft <= '0;
      pollMode  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (tdi) state <= ST_HDR;
        ST_HDR: begin
          hdrBits <= nextHdr[6:1];
          hdrCnt  <= hdrCnt + 3'd1;
          if (hdrCnt == 3'd6) begin
            unique case (nextHdr[1:0])
              MODE_SHORT: begin
                bytesLeft <= LEN_W'(nextHdr[6:2]);
                pollMode  <= 1'b0;
                state     <= (nextHdr[6:2] != 5'd0) ? ST_DATA : ST_WAIT;
              end
              MODE_LONG: state <= ST_EXT;
              MODE_POLL: begin
                pollMode <= 1'b1;
                state    <= ST_DATA;
              end
              default: state <= ST_WAIT;
            endcase
          end
        end
        ST_EXT: begin
          extBits <= nextExt[EXT_W-1:1];
          extCnt  <= extCnt + 1'b1;
          if (extCnt == EXTC_W'(EXT_W - 1)) begin
            bytesLeft <= longLen;
            pollMode  <= 1'b0;
            state     <= (longLen != '0) ? ST_DATA : ST_WAIT;
          end
        end
        ST_DATA: begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7 && !pollMode) begin
            if (bytesLeft == LEN_W'(1)) state <= ST_TAIL;
            else bytesLeft <= bytesLeft - 1'b1;
          end
        end
        ST_TAIL: state <= ST_WAIT;
        default: state <= ST_WAIT;
      endcase
    end
  end

  // R3: a counted frame never runs with nothing left to send
  p_bytes_live_r3: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_DATA && !pollMode) |-> (bytesLeft != '0));

  // R5: a short header with zero length never opens a frame
  p_zero_len_ignored_r5: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_HDR && hdrCnt == 3'd6 && nextHdr[1:0] == MODE_SHORT &&
     nextHdr[6:2] == 5'd0) |=> (state != ST_DATA));

  // R9: the capture slot after the last counted bit lasts one edge
  p_tail_once_r9: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_TAIL) |=> (state != ST_TAIL && state != ST_DATA));

endmodule

// File: rtl/jtag_spi_bridge_dp.sv
module jtag_spi_bridge_dp
  import jtag_spi_bridge_pkg::*;
#(
  parameter int                     VER_CHARS = 5,
  parameter logic [8*VER_CHARS-1:0] VER_TEXT  = "2.0  "
) (
  input  logic          tck,
  input  logic          rstN,
  input  bridgeStrobe_t st,
  input  logic          tdi,
  input  logic          spiMiso,
  input  logic          selVer,
  input  logic          shiftDr,
  output logic          spiCsN,
  output logic          clkEn,
  output logic          spiMosi,
  output logic          tdo
);

  localparam int VER_BITS = 8 * (VER_CHARS + 1);
  localparam int VCNT_W   = $clog2(VER_BITS + 1);

  logic              dataTdo;
  logic              verTdo;
  logic [VCNT_W-1:0] vCnt;
  logic              verBitNow;

  always_ff @(posedge tck) begin
    if (!rstN || st.clear) begin
      spiCsN  <= 1'b1;
      clkEn   <= 1'b0;
      spiMosi <= 1'b0;
      dataTdo <= 1'b0;
    end else begin
      spiCsN  <= !st.frameOn;
      clkEn   <= st.frameOn;
      if (st.frameOn) spiMosi <= tdi;
      dataTdo <= st.sampleEn ? spiMiso : 1'b0;
    end
  end

  always_comb begin
    int charIdx;
    int bitIdx;
    charIdx   = int'(vCnt) / 8;
    bitIdx    = int'(vCnt) % 8;
    verBitNow = 1'b0;
    if (charIdx >= 1 && charIdx <= VER_CHARS)
      verBitNow = VER_TEXT[8 * (VER_CHARS - charIdx) + bitIdx];
  end

  always_ff @(posedge tck) begin
    if (!rstN || !selVer || !shiftDr) begin
      vCnt   <= '0;
      verTdo <= 1'b0;
    end else begin
      verTdo <= verBitNow;
      if (vCnt != VCNT_W'(VER_BITS)) vCnt <= vCnt + 1'b1;
    end
  end

  assign tdo = selVer ? verTdo : dataTdo;

  // R10: leaving the shift state closes the frame on the next edge
  p_cs_drop_on_exit_r10: assert property (@(posedge tck) disable iff (!rstN)
    (!shiftDr) |=> spiCsN);

  // R12: the leading byte of the revision scan reads as zero
  p_ver_lead_zero_r12: assert property (@(posedge tck) disable iff (!rstN)
    (selVer && shiftDr && vCnt < VCNT_W'(8)) |=> (verTdo == 1'b0));

endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
  import jtag_spi_bridge_pkg::*;
#(
  parameter int                     EXT_W     = 8,
  parameter int                     VER_CHARS = 5,
  parameter logic [8*VER_CHARS-1:0] VER_TEXT  = "2.0  "
) (
  input  logic tck,
  input  logic rstN,
  input  logic selData,
  input  logic selVer,
  input  logic shiftDr,
  input  logic updateDr,
  input  logic tdi,
  output logic tdo,
  output logic spiCsN,
  output logic spiClk,
  output logic spiMosi,
  input  logic spiMiso
);

  bridgeStrobe_t st;
  logic          clkEn;

  jtag_spi_bridge_ctrl #(.EXT_W(EXT_W)) u_ctrl (
    .tck      (tck),
    .rstN     (rstN),
    .selData  (selData),
    .shiftDr  (shiftDr),
    .updateDr (updateDr),
    .tdi      (tdi),
    .st       (st)
  );

  jtag_spi_bridge_dp #(.VER_CHARS(VER_CHARS), .VER_TEXT(VER_TEXT)) u_dp (
    .tck     (tck),
    .rstN    (rstN),
    .st      (st),
    .tdi     (tdi),
    .spiMiso (spiMiso),
    .selVer  (selVer),
    .shiftDr (shiftDr),
    .spiCsN  (spiCsN),
    .clkEn   (clkEn),
    .spiMosi (spiMosi),
    .tdo     (tdo)
  );

  // flash clock rises in the low half of TCK, while MOSI is settled
  assign spiClk = ~tck & clkEn;

  // R11: dropping the instruction leaves the flash idle next edge
  p_deselect_idle_r11: assert property (@(posedge tck) disable iff (!rstN)
    (!selData) |=> (spiCsN && !clkEn));

endmodule

// File: tb/jtag_spi_bridge_bench.sv
module jtag_spi_bridge_bench;

  logic tck = 1'b0;
  logic rstN, selData, selVer, shiftDr, updateDr, tdi, spiMiso;
  logic tdo, spiCsN, spiClk, spiMosi;

  always #5 tck = ~tck;

  jtag_spi_bridge u_jtag_spi_bridge (
    .tck(tck), .rstN(rstN), .selData(selData), .selVer(selVer),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .spiCsN(spiCsN), .spiClk(spiClk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int total = 0;
  int bad = 0;
  bit txBits [0:4095];
  bit rxBits [0:4095];
  byte unsigned mosiQ [$];
  int frameQ [$];
  int framesSeen = 0;
  int riseCnt = 0;
  bit frameOpen = 0;
  byte unsigned inSh = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic byte unsigned patByte(input int k);
    return 8'h3C + 8'(k * 5);
  endfunction

  // flash model: monitor side of the scoreboard
  always @(negedge spiCsN) if (rstN === 1'b1) begin
    riseCnt = 0; frameOpen = 1; framesSeen++;
  end
  always @(posedge spiCsN) if (frameOpen) begin
    frameOpen = 0;
    if (frameQ.size() == 0) check(0, "R9 unexpected frame", riseCnt / 8, 0);
    else begin
      int expB;
      expB = frameQ.pop_front();
      check(riseCnt / 8 == expB, "R9 frame byte count", riseCnt / 8, expB);
    end
  end
  always @(posedge spiClk) if (spiCsN === 1'b0) begin
    inSh = {inSh[6:0], spiMosi};
    riseCnt++;
    if (riseCnt % 8 == 0) begin
      if (mosiQ.size() == 0) check(0, "R7 mosi byte unexpected", inSh, 0);
      else begin
        byte unsigned e;
        e = mosiQ.pop_front();
        check(inSh == e, "R7 mosi byte", inSh, e);
      end
    end
  end
  always @(negedge spiClk) if (spiCsN === 1'b0 && riseCnt >= 8) begin
    int m;
    byte unsigned pb;
    m = riseCnt - 8;
    pb = patByte(m / 8);
    #1 spiMiso = pb[7 - (m % 8)];
  end

  task automatic shiftStream(input int n);
    for (int q = 0; q < n; q++) begin
      @(negedge tck);
      if (q > 0) rxBits[q-1] = tdo;
      tdi = txBits[q];
      shiftDr = 1'b1;
    end
    @(negedge tck);
    rxBits[n-1] = tdo;
    shiftDr = 1'b0;
    tdi = 1'b0;
    repeat (3) @(negedge tck);
  endtask

  // driver: builds a packet, pushes expectations, shifts it
  task automatic sendPkt(input int mode, input int len, input int leadZ,
                         input byte unsigned cmd, input bit doRead,
                         input int cut, input bit expectFrame, input string tag);
    int hb, nb, n, f0;
    byte unsigned hdr, ext, v;
    hb = leadZ + 8 + ((mode == 0) ? 8 : 0);
    nb = (cut > 0) ? cut : len;
    n = hb + 8 * nb + ((cut > 0) ? 0 : 1) + (expectFrame ? 0 : 16);
    for (int i = 0; i < n; i++) txBits[i] = 1'b0;
    hdr = {5'(len), 2'(mode), 1'b1};
    ext = 8'(len >> 5);
    for (int j = 0; j < 8; j++) begin
      txBits[leadZ + j] = hdr[j];
      if (mode == 0) txBits[leadZ + 8 + j] = ext[j];
    end
    for (int i = 0; i < nb; i++) begin
      v = (i == 0) ? cmd : (doRead ? 8'h00 : 8'(8'h10 + i));
      for (int j = 0; j < 8; j++) txBits[hb + 8*i + j] = v[7-j];
      if (expectFrame) mosiQ.push_back(v);
    end
    if (expectFrame) frameQ.push_back(nb);
    f0 = framesSeen;
    shiftStream(n);
    check(framesSeen - f0 == int'(expectFrame), {tag, " frame opened"}, framesSeen - f0, int'(expectFrame));
    check(spiCsN === 1'b1, {tag, " R10 cs high after shift"}, spiCsN, 1);
    if (expectFrame) begin
      check(mosiQ.size() == 0, {tag, " R7 bytes all seen"}, mosiQ.size(), 0);
      check(frameQ.size() == 0, {tag, " R9 frame closed"}, frameQ.size(), 0);
    end
    if (doRead)
      for (int k = 0; k < nb - 1; k++) begin
        byte unsigned r;
        for (int j = 0; j < 8; j++) r[7-j] = rxBits[hb + 9 + 8*k + j];
        check(r == patByte(k), {tag, " R8 reply byte"}, r, patByte(k));
      end
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 0; selData = 0; selVer = 0; shiftDr = 0; updateDr = 0; tdi = 0; spiMiso = 0;
    repeat (4) @(negedge tck);
    rstN = 1;
    @(negedge tck);
    check(spiCsN === 1'b1, "R1 cs after reset", spiCsN, 1);
    check(spiClk === 1'b0, "R1 clk after reset", spiClk, 0);
    check(tdo === 1'b0, "R1 tdo after reset", tdo, 0);

    selData = 1;
    sendPkt(1, 4, 0, 8'h02, 0, 0, 1, "R3 short write len4");
    sendPkt(1, 1, 0, 8'h06, 0, 0, 1, "R3 command only");
    sendPkt(1, 31, 0, 8'h0B, 1, 0, 1, "R3 short read len31");
    sendPkt(0, 32, 0, 8'h0B, 1, 0, 1, "R4 long read len32");
    sendPkt(0, 33, 3, 8'h03, 1, 0, 1, "R2 lead zeros R4 len33");
    sendPkt(0, 300, 0, 8'h02, 0, 0, 1, "R4 long write len300");
    sendPkt(0, 300, 0, 8'h03, 1, 0, 1, "R4 long read len300");
    sendPkt(1, 0, 0, 8'h02, 0, 0, 0, "R5 zero length");
    sendPkt(3, 5, 0, 8'h02, 0, 0, 0, "R5 reserved mode");
    sendPkt(2, 4, 0, 8'h05, 1, 0, 1, "R6 poll");
    sendPkt(1, 10, 0, 8'h02, 0, 2, 1, "R10 early exit");
    selData = 0;
    sendPkt(1, 4, 0, 8'h02, 0, 0, 0, "R11 deselected");

    // R12: revision scan
    selVer = 1;
    for (int i = 0; i < 48; i++) txBits[i] = 1'b0;
    shiftStream(48);
    selVer = 0;
    begin
      byte unsigned expC [0:5];
      byte unsigned got;
      expC = '{8'h00, 8'h32, 8'h2E, 8'h30, 8'h20, 8'h20};
      for (int c = 0; c < 6; c++) begin
        for (int j = 0; j < 8; j++) got[j] = rxBits[8*c + j];
        check(got == expC[c], "R12 revision byte", got, expC[c]);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule